// File: doc/BRIEF.md
# Daisy-Chain Status Frame Forwarder

This block is the link logic of one acquisition node in a linear chain of up to `MAX_NODES` nodes. The node furthest from the master is at the tail of the chain. Each node receives a status frame from the node below it and checks that frame's trailing CRC-32. It then adds a record of its own, made of its node number, two flag bits and a snapshot of its local status vector. It regenerates the CRC and sends the longer frame one hop up the chain. The next hop is either another node or the master.

An internal cadence timer starts one outgoing frame every `PERIOD` clock cycles. The default of 125 cycles gives a 1 µs interval at 125 MHz. A downstream frame that fails its CRC is not passed on silently. Its records are withheld and the node's own record carries a link-error flag. A period in which no downstream frame completes makes the node's own record carry a timeout flag. A tail node builds each frame from its own record alone.

Both link ports are word-wide valid/data streams. The serializer and the transceiver sit outside the block. Received records are held in a two-bank word memory, so a frame can be received while the previous one is being sent.

Top module: `chain_status_relay`

## Requirements
- R1: An outgoing frame is one contiguous run of 3*N+2 words with `tx_valid` high on every word, and N is the record count.
  - The first word holds 0xFA57 in bits [31:16], zero in bits [15:8] and N (1..MAX_NODES) in bits [7:0].
  - The N three-word records follow. A record is a header word (node number in [31:24], zero in [23:2], timeout flag in bit 1, link-error flag in bit 0), then status bits [63:32], then status bits [31:0].
  - The last word is the CRC.
- R2: The last word of every outgoing frame is the CRC-32 of all the words before it, starting with the first word.
  - The polynomial is 0x04C11DB7.
  - Each word is processed most significant bit first.
  - The register starts at 0xFFFFFFFF and is inverted at the end.
- R3: The first words of successive outgoing frames are exactly `PERIOD` cycles apart.
- R4: A downstream frame that is well formed and passes its CRC, received within a period, is forwarded at the next frame start, as follows.
  - Its records are passed on unchanged and in their original order.
  - The node's own record is placed last.
  - The record count is the incoming count plus one.
  - Both flags are clear.
- R5: While `tail_mode` is high, the downstream port is ignored. Each frame holds only the node's own record, with both flags clear.
- R6: A downstream frame whose CRC word does not match is not forwarded. The next frame holds only the node's own record, with the link-error flag set and the timeout flag clear.
- R7: If no downstream frame completes within a period, the next frame holds only the node's own record, with the timeout flag set and the link-error flag clear.
- R8: A downstream first word whose count field is 0 or at least `MAX_NODES` is treated as a link error, as in R6.
- R9: A downstream frame is forwarded at most once. If the following period receives nothing, the next frame shows a timeout.
- R10: `tx_valid` stays low during reset and until the first frame start, `PERIOD` cycles after reset is released.
- R11: The status and flags in the node's own record are the values sampled at the frame start. A change of `local_status` while the frame is being sent does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tail_mode | input | 1 | Node is last in the chain and originates frames |
| node_id | input | 8 | Number written into the node's own record |
| local_status | input | STATUS_W | Local input status vector |
| rx_valid | input | 1 | Downstream word valid |
| rx_data | input | 32 | Downstream word |
| tx_valid | output | 1 | Upstream word valid |
| tx_data | output | 32 | Upstream word |

## Verification
The bench builds the block with `PERIOD` = 48 and `MAX_NODES` = 4, keeping the 64-bit status. With the short period, many frame intervals fit in one short run, so timeouts, repeated forwarding and the cadence spacing are each seen several times. With `MAX_NODES` = 4, a three-record downstream frame reaches the top of the record count. A count of 4 from downstream then falls just past the limit and exercises the malformed-count path.

// File: rtl/chain_relay_pkg.sv
package chain_relay_pkg;
  localparam int WORD_W = 32;
  localparam logic [15:0] SOF_TAG = 16'hFA57;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  typedef enum logic [1:0] {RX_IDLE, RX_BODY, RX_CRC} rx_state_t;

  // One 32-bit word folded into the CRC register, MSB first.
  function automatic logic [31:0] crc32_step(input logic [31:0] acc, input logic [31:0] din);
    logic [31:0] c;
    logic fb;
    c = acc;
    for (int i = 31; i >= 0; i--) begin
      fb = c[31] ^ din[i];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction
endpackage

// File: rtl/cl_cadence.sv
module cl_cadence #(
  parameter int PERIOD = 125
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (cnt == CW'(PERIOD - 1)) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cl_frame_ram.sv
module cl_frame_ram #(
  parameter int DEPTH = 36,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cl_rx_parser.sv
module cl_rx_parser
  import chain_relay_pkg::*;
#(
  parameter int MAX_NODES = 7,
  parameter int REC_WORDS = 3,
  parameter int SLOT      = 18,
  parameter int AW        = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          rx_valid,
  input  logic [31:0]   rx_data,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [31:0]   wdata,
  output logic          good_pulse,
  output logic          bad_pulse,
  output logic          ready_bank,
  output logic [7:0]    ready_cnt
);
  rx_state_t     state;
  logic [7:0]    cnt_r;
  logic [AW-1:0] widx, last_w;
  logic          wr_bank;
  logic [31:0]   crc_acc;

  always_comb begin
    we    = enable && rx_valid && (state == RX_BODY);
    waddr = (wr_bank ? AW'(SLOT) : '0) + widx;
    wdata = rx_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RX_IDLE;
      cnt_r      <= '0;
      widx       <= '0;
      last_w     <= '0;
      wr_bank    <= 1'b0;
      crc_acc    <= '1;
      good_pulse <= 1'b0;
      bad_pulse  <= 1'b0;
      ready_bank <= 1'b0;
      ready_cnt  <= '0;
    end else begin
      good_pulse <= 1'b0;
      bad_pulse  <= 1'b0;
      if (!enable) begin
        state <= RX_IDLE;
      end else if (rx_valid) begin
        case (state)
          RX_IDLE: begin
            if (rx_data[31:16] == SOF_TAG) begin
              crc_acc <= crc32_step('1, rx_data);
              if (rx_data[7:0] == 8'd0 || rx_data[7:0] >= 8'(MAX_NODES)) begin
                bad_pulse <= 1'b1;
              end else begin
                cnt_r  <= rx_data[7:0];
                widx   <= '0;
                last_w <= AW'(rx_data[7:0]) * AW'(REC_WORDS) - AW'(1);
                state  <= RX_BODY;
              end
            end
          end
          RX_BODY: begin
            crc_acc <= crc32_step(crc_acc, rx_data);
            widx    <= widx + 1'b1;
            if (widx == last_w) state <= RX_CRC;
          end
          RX_CRC: begin
            state <= RX_IDLE;
            if (rx_data == ~crc_acc) begin
              good_pulse <= 1'b1;
              ready_bank <= wr_bank;
              ready_cnt  <= cnt_r;
              wr_bank    <= ~wr_bank;
            end else begin
              bad_pulse <= 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cl_tx_builder.sv
module cl_tx_builder
  import chain_relay_pkg::*;
#(
  parameter int MAX_NODES = 7,
  parameter int STATUS_W  = 64,
  parameter int REC_WORDS = 3,
  parameter int SLOT      = 18,
  parameter int AW        = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [7:0]          fwd_cnt,
  input  logic                fwd_bank,
  input  logic [31:0]         own_hdr,
  input  logic [STATUS_W-1:0] local_status,
  input  logic [31:0]         ram_q,
  output logic [AW-1:0]       raddr,
  output logic                tx_valid,
  output logic [31:0]         tx_data
);
  localparam int IW = $clog2(MAX_NODES * REC_WORDS + 2) + 1;
  localparam int KW = (REC_WORDS > 1) ? $clog2(REC_WORDS) : 1;

  logic                busy, bank, s1_v;
  logic [IW-1:0]       idx, s1_idx, body_end, last_idx, k;
  logic [7:0]          n_fwd;
  logic [31:0]         hdr_l, crc_r, word;
  logic [STATUS_W-1:0] stat_l;
  logic [31:0]         own_w [REC_WORDS];

  always_comb begin
    own_w[0] = hdr_l;
    for (int j = 1; j < REC_WORDS; j++) own_w[j] = stat_l[STATUS_W - 32*j +: 32];
  end

  // stage 0: address for the forwarded record words
  always_comb begin
    if (idx == '0 || idx > body_end) raddr = bank ? AW'(SLOT) : '0;
    else raddr = (bank ? AW'(SLOT) : '0) + AW'(idx - 1'b1);
  end

  // stage 1: word selection
  always_comb begin
    k = s1_idx - body_end - 1'b1;
    if (s1_idx == '0)           word = {SOF_TAG, 8'h00, n_fwd + 8'd1};
    else if (s1_idx <= body_end) word = ram_q;
    else if (s1_idx < last_idx)  word = own_w[k[KW-1:0]];
    else                         word = ~crc_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      idx      <= '0;
      s1_v     <= 1'b0;
      s1_idx   <= '0;
      n_fwd    <= '0;
      bank     <= 1'b0;
      hdr_l    <= '0;
      stat_l   <= '0;
      body_end <= '0;
      last_idx <= '0;
      crc_r    <= '1;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      s1_v   <= busy;
      s1_idx <= idx;
      if (tick) begin
        busy     <= 1'b1;
        idx      <= '0;
        n_fwd    <= fwd_cnt;
        bank     <= fwd_bank;
        hdr_l    <= own_hdr;
        stat_l   <= local_status;
        body_end <= IW'(fwd_cnt) * IW'(REC_WORDS);
        last_idx <= IW'(fwd_cnt) * IW'(REC_WORDS) + IW'(REC_WORDS) + IW'(1);
      end else if (busy) begin
        idx <= idx + 1'b1;
        if (idx == last_idx) busy <= 1'b0;
      end
      tx_valid <= s1_v;
      if (s1_v) begin
        tx_data <= word;
        crc_r   <= (s1_idx == '0) ? crc32_step('1, word) : crc32_step(crc_r, word);
      end
    end
  end
endmodule

// File: rtl/chain_status_relay.sv
module chain_status_relay #(
  parameter int PERIOD    = 125,
  parameter int MAX_NODES = 7,
  parameter int STATUS_W  = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tail_mode,
  input  logic [7:0]          node_id,
  input  logic [STATUS_W-1:0] local_status,
  input  logic                rx_valid,
  input  logic [31:0]         rx_data,
  output logic                tx_valid,
  output logic [31:0]         tx_data
);
  localparam int REC_WORDS = 1 + STATUS_W / 32;
  localparam int SLOT      = (MAX_NODES - 1) * REC_WORDS;
  localparam int DEPTH     = 2 * SLOT;
  localparam int AW        = $clog2(DEPTH);

  logic          tick, we, good_pulse, bad_pulse, ready_bank;
  logic [AW-1:0] waddr, raddr;
  logic [31:0]   wdata, ram_q, own_hdr;
  logic [7:0]    ready_cnt, fwd_cnt;
  logic          good_seen, bad_seen, tmo, link_err;

  cl_cadence #(.PERIOD(PERIOD)) u_cad (.clk(clk), .rst(rst), .tick(tick));

  cl_rx_parser #(.MAX_NODES(MAX_NODES), .REC_WORDS(REC_WORDS), .SLOT(SLOT), .AW(AW)) u_rx (
    .clk(clk), .rst(rst), .enable(!tail_mode), .rx_valid(rx_valid), .rx_data(rx_data),
    .we(we), .waddr(waddr), .wdata(wdata), .good_pulse(good_pulse), .bad_pulse(bad_pulse),
    .ready_bank(ready_bank), .ready_cnt(ready_cnt));

  cl_frame_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata), .raddr(raddr), .rdata(ram_q));

  // events collected over one cadence period
  always_ff @(posedge clk) begin
    if (rst) begin
      good_seen <= 1'b0;
      bad_seen  <= 1'b0;
    end else if (tick) begin
      good_seen <= good_pulse;
      bad_seen  <= bad_pulse;
    end else begin
      good_seen <= good_seen | good_pulse;
      bad_seen  <= bad_seen | bad_pulse;
    end
  end

  always_comb begin
    fwd_cnt  = (tail_mode || !good_seen) ? 8'd0 : ready_cnt;
    link_err = !tail_mode && bad_seen;
    tmo      = !tail_mode && !good_seen && !bad_seen;
    own_hdr  = {node_id, 22'd0, tmo, link_err};
  end

  cl_tx_builder #(.MAX_NODES(MAX_NODES), .STATUS_W(STATUS_W), .REC_WORDS(REC_WORDS),
                  .SLOT(SLOT), .AW(AW)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .fwd_cnt(fwd_cnt), .fwd_bank(ready_bank),
    .own_hdr(own_hdr), .local_status(local_status), .ram_q(ram_q), .raddr(raddr),
    .tx_valid(tx_valid), .tx_data(tx_data));
endmodule

// File: rtl/chain_status_relay_chk.sv
module chain_status_relay_chk #(
  parameter int PERIOD    = 125,
  parameter int MAX_NODES = 7,
  parameter int REC_WORDS = 3
) (
  input logic        clk,
  input logic        rst,
  input logic        tx_valid,
  input logic [31:0] tx_data,
  input logic [7:0]  node_id
);
  logic        in_frame, seen_sof;
  logic [15:0] rem;
  logic [31:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      seen_sof <= 1'b0;
      rem      <= '0;
      gap      <= '0;
    end else begin
      if (gap != '1) gap <= gap + 1'b1;
      if (tx_valid) begin
        if (!in_frame) begin
          in_frame <= 1'b1;
          rem      <= 16'(tx_data[7:0]) * 16'(REC_WORDS) + 16'd1;
          gap      <= 32'd1;
          seen_sof <= 1'b1;
        end else begin
          rem <= rem - 1'b1;
          if (rem == 16'd1) in_frame <= 1'b0;
        end
      end
    end
  end

  // R1
  frame_start_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !in_frame) |-> (tx_data[31:8] == {16'hFA57, 8'h00}));
  // R1
  record_count_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !in_frame) |-> (tx_data[7:0] >= 8'd1 && tx_data[7:0] <= 8'(MAX_NODES)));
  // R1
  no_gap_chk: assert property (@(posedge clk) disable iff (rst)
    in_frame |-> tx_valid);
  // R3
  cadence_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !in_frame && seen_sof) |-> (gap == 32'(PERIOD)));
  // R1
  own_header_chk: assert property (@(posedge clk) disable iff (rst)
    (in_frame && rem == 16'(REC_WORDS + 1)) |-> (tx_data[31:24] == node_id && tx_data[23:2] == 22'd0));
  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (in_frame && rem == 16'(REC_WORDS + 1)) |-> !(tx_data[1] && tx_data[0]));
endmodule

bind chain_status_relay chain_status_relay_chk #(
  .PERIOD(PERIOD), .MAX_NODES(MAX_NODES), .REC_WORDS(REC_WORDS)
) u_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_data(tx_data), .node_id(node_id)
);

// File: tb/sim_chain_status_relay.sv
module sim_chain_status_relay;
  localparam int P  = 48;
  localparam int MN = 4;
  localparam logic [7:0] NID = 8'h2C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tail_mode = 1'b0;
  logic [63:0] local_status = 64'h0123_4567_89AB_CDEF;
  logic        rx_valid = 1'b0;
  logic [31:0] rx_data = '0;
  logic        tx_valid;
  logic [31:0] tx_data;

  chain_status_relay #(.PERIOD(P), .MAX_NODES(MN), .STATUS_W(64)) u0 (
    .clk(clk), .rst(rst), .tail_mode(tail_mode), .node_id(NID), .local_status(local_status),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid), .tx_data(tx_data));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  logic [31:0] cap [0:31];
  logic [31:0] frm [0:31];
  logic [31:0] sent [0:15];
  int cap_n = 0, cap_need = 0, frm_len = 0, frames = 0, last_sof = 0, sof_gap = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst && tx_valid) begin
      if (cap_n == 0) begin
        cap_need = int'(tx_data[7:0]) * 3 + 2;
        sof_gap  = cyc - last_sof;
        last_sof = cyc;
      end
      if (cap_n < 32) cap[cap_n] = tx_data;
      cap_n++;
      if (cap_n >= cap_need || cap_n >= 32) begin
        for (int i = 0; i < 32; i++) frm[i] = cap[i];
        frm_len = cap_n;
        cap_n = 0;
        frames++;
      end
    end
  end

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int w = 0; w < n; w++)
      for (int b = 31; b >= 0; b--) begin
        logic top = c[31] ^ frm[w][b];
        c = c << 1;
        if (top) c = c ^ 32'h04C1_1DB7;
      end
    return ~c;
  endfunction

  task automatic wait_frame();
    int f = frames;
    while (frames == f) @(negedge clk);
  endtask

  // builds and drives a downstream frame; cntf overrides the count field
  task automatic send_frame(input int n, input int cntf, input bit corrupt, input int seed);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [31:0] w;
    for (int i = 0; i < 3 * n + 2; i++) begin
      if (i == 0) w = {16'hFA57, 8'h00, 8'(cntf)};
      else if (i == 3 * n + 1) w = corrupt ? c : ~c;
      else begin
        case ((i - 1) % 3)
          0: w = {8'(8'h10 + (i - 1) / 3 + seed), 22'd0, 2'((i - 1) / 3)};
          1: w = 32'hA500_0000 + 32'(seed * 256 + i);
          default: w = 32'h5A00_0000 ^ 32'(seed * 4096 + i * 7);
        endcase
        sent[i - 1] = w;
      end
      if (i != 3 * n + 1)
        for (int b = 31; b >= 0; b--) begin
          logic top = c[31] ^ w[b];
          c = c << 1;
          if (top) c = c ^ 32'h04C1_1DB7;
        end
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = w;
    end
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic check_frame(input string req, input int nfwd, input bit to, input bit le,
                             input logic [63:0] st);
    int own = 1 + 3 * nfwd;
    cmp({req, " len"}, 32'(frm_len), 32'(3 * nfwd + 5));
    cmp({req, " sof"}, frm[0], {16'hFA57, 8'h00, 8'(nfwd + 1)});
    for (int i = 0; i < 3 * nfwd; i++) cmp({req, " fwd word"}, frm[1 + i], sent[i]);
    cmp({req, " own hdr"}, frm[own], {NID, 22'd0, to, le});
    cmp({req, " own hi"}, frm[own + 1], st[63:32]);
    cmp({req, " own lo"}, frm[own + 2], st[31:0]);
    cmp({req, " R2 crc"}, frm[own + 3], ref_crc(own + 3));
  endtask

  task automatic t_reset();
    bit seen = 0;
    rst = 1'b1;
    repeat (5) begin @(negedge clk); if (tx_valid) seen = 1; end
    rst = 1'b0;
    repeat (P - 1) begin @(negedge clk); if (tx_valid) seen = 1; end
    cmp("R10 tx_valid quiet", 32'(seen), 0);
    wait_frame();
    check_frame("R7 first", 0, 1, 0, local_status);
  endtask

  task automatic t_timeout();
    wait_frame();
    check_frame("R7 idle", 0, 1, 0, local_status);
    cmp("R3 spacing", 32'(sof_gap), 32'(P));
  endtask

  task automatic t_forward(input int n, input int seed);
    send_frame(n, n, 0, seed);
    wait_frame();
    check_frame("R4 forward", n, 0, 0, local_status);
    cmp("R3 spacing", 32'(sof_gap), 32'(P));
  endtask

  task automatic t_badcrc();
    send_frame(2, 2, 1, 3);
    wait_frame();
    check_frame("R6 bad crc", 0, 0, 1, local_status);
  endtask

  task automatic t_malformed();
    send_frame(0, MN, 0, 0);
    wait_frame();
    check_frame("R8 count max", 0, 0, 1, local_status);
    send_frame(0, 0, 0, 0);
    wait_frame();
    check_frame("R8 count zero", 0, 0, 1, local_status);
  endtask

  task automatic t_norepeat();
    send_frame(1, 1, 0, 5);
    wait_frame();
    check_frame("R9 first", 1, 0, 0, local_status);
    wait_frame();
    check_frame("R9 no repeat", 0, 1, 0, local_status);
  endtask

  task automatic t_snapshot();
    logic [63:0] a = 64'hDEAD_BEEF_0BAD_F00D;
    logic [63:0] b = 64'h1111_2222_3333_4444;
    local_status = a;
    wait_frame();
    while (!tx_valid) @(negedge clk);
    local_status = b;
    wait_frame();
    check_frame("R11 snapshot", 0, 1, 0, a);
    wait_frame();
    check_frame("R11 next", 0, 1, 0, b);
  endtask

  task automatic t_tail();
    tail_mode = 1'b1;
    wait_frame();
    check_frame("R5 tail idle", 0, 0, 0, local_status);
    send_frame(2, 2, 0, 7);
    wait_frame();
    check_frame("R5 tail ignores rx", 0, 0, 0, local_status);
    tail_mode = 1'b0;
    wait_frame();
    wait_frame();
    check_frame("R7 after tail", 0, 1, 0, local_status);
  endtask

  initial begin
    t_reset();
    t_timeout();
    t_forward(2, 1);
    t_forward(3, 2);
    t_badcrc();
    t_malformed();
    t_norepeat();
    t_snapshot();
    t_tail();
    t_forward(1, 9);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule